// File: doc/BRIEF.md
# E1 Frame Alignment Detector

This block takes the serial bitstream of a 2048 kbit/s E1 line, one bit each time a clock enable is high, and finds the boundary of the 256-bit basic frame. A frame holds 32 timeslots of 8 bits, and it repeats 8000 times a second. Timeslot 0 carries an alignment word in every other frame. In the frames between them, bit 2 of timeslot 0 is held at one. The block slides a 7-bit window over the stream until the word appears. It then checks that the next frame lacks the word and that the frame after that has it again. Only after both checks does it declare alignment.

Once aligned, the block counts bits modulo 256. It checks timeslot 0 once per frame and drops alignment after three wrong words in a row, or after three wrong bit-2 values in a row in the frames that carry no word. The outputs are position information for the bit that comes next: the bit number, the timeslot number, a frame-start flag and a flag that marks frames carrying the word. Line decoding, clock recovery, multiframe CRC handling and signalling-slot processing belong to other blocks.

Top module: `e1fa_top`

## Requirements
- R1: A synchronous active-high reset leaves `inFrame`, `frameStart` and `fasFrame` low and `bitNum` at 1. The block then hunts again from the next accepted bit.
- R2: Bits are numbered 1..8 within timeslot 0 in the order they arrive. The alignment word is bits 2..8 equal to 0,0,1,1,0,1,1. Bit 1 is not compared, so the timeslot 0 bytes 0x1B and 0x9B (bit 1 as MSB) both count as correct.
- R3: The block takes a word found at any bit position as candidate frame n. `inFrame` rises right after bit 8 of timeslot 0 of frame n+2, with `bitNum` = 9, provided the word is absent at that position in frame n+1 and present in frame n+2. During the frame n+1 check, bit 2 is not examined.
- R4: If the word is present in frame n+1, no new candidate is accepted until the counter that started at the candidate wraps past bit 256. Hunting resumes at the first bit of frame n+2.
- R5: If the word is missing in frame n+2, hunting resumes with the very next bit.
- R6: While aligned, a wrong word in three consecutive word-carrying frames clears `inFrame` right after bit 8 of the third one. A correct word resets this count.
- R7: While aligned, bit 2 = 0 in three consecutive frames without the word clears `inFrame` right after bit 8 of the third one. Bit 2 = 1 resets this count. The two counts are independent of each other.
- R8: While aligned, `bitNum` (1..256) gives the position of the next bit to be accepted and wraps from 256 to 1. `slotNum` is (bitNum-1)/8. `frameStart` is high exactly when `inFrame` is high and `bitNum` = 1.
- R9: `fasFrame` is high while aligned and the current frame is one that carries the word. It alternates at each frame wrap.
- R10: A cycle with `bitEn` low changes neither the position outputs nor `inFrame`, whatever `bitIn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bitEn | input | 1 | Qualifies `bitIn` for one clock |
| bitIn | input | 1 | Serial line data |
| inFrame | output | 1 | Frame alignment held |
| bitNum | output | 9 | Position 1..256 of the next bit |
| slotNum | output | 5 | Timeslot 0..31 of the next bit |
| frameStart | output | 1 | Next bit is bit 1 of a frame while aligned |
| fasFrame | output | 1 | Current frame carries the alignment word |

## Verification
The hardest situations to reach are the two failed confirmations. From the ports, the internal candidate cannot be seen. The stimulus therefore plants a decoy copy of the alignment word inside a payload timeslot, so the hunt locks onto it. In one case the decoy is repeated one frame later, and a genuine word is placed in the following timeslot 0, inside the hold-off window. In the other case the decoy is dropped in the third frame, and a genuine word is placed right after it. In each case the frame in which `inFrame` rises differs by two frames between a correct design and one that gets the restart point wrong.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic lock;      // reload the bit counter at a fresh candidate
  } ctrlStrb_t;

  // observations from the datapath for the control FSM
  typedef struct packed {
    logic hitNow;    // accepted bit completes an alignment word
    logic atCheck;   // accepted bit is bit 8 of timeslot 0
    logic atWrap;    // accepted bit is the last bit of a frame
    logic fasHit;    // window equals the alignment word
    logic spareOk;   // bit 2 of the window is one
    logic curFas;    // current frame is a word-carrying frame
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_WANT_ABSENT,
    ST_HOLD_OFF,
    ST_WANT_PRESENT,
    ST_LOCKED
  } alignSt_t;

endpackage

// File: rtl/e1fa_datapath.sv
module e1fa_datapath
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter logic [SLOT_BITS-2:0] FAS_WORD = 7'b0011011,
  localparam int CNT_W  = $clog2(FRAME_BITS + 1),
  localparam int SLOT_W = $clog2(FRAME_BITS / SLOT_BITS),
  localparam int PAT_W  = SLOT_BITS - 1,
  localparam int SLOT_SH = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              bitIn,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic [CNT_W-1:0]  bitNum,
  output logic [SLOT_W-1:0] slotNum
);

  logic [PAT_W-2:0] histReg;
  logic [PAT_W-1:0] window;
  logic [CNT_W-1:0] posCnt;
  logic             fasPhase;
  logic [CNT_W-1:0] posLess;
  logic             lastBit;

  assign window  = {histReg, bitIn};
  assign lastBit = (posCnt == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      histReg  <= '0;
      posCnt   <= CNT_W'(1);
      fasPhase <= 1'b0;
    end else if (bitEn) begin
      histReg <= window[PAT_W-2:0];
      if (strb.lock) begin
        posCnt   <= CNT_W'(SLOT_BITS + 1);
        fasPhase <= 1'b1;
      end else if (lastBit) begin
        posCnt   <= CNT_W'(1);
        fasPhase <= ~fasPhase;
      end else begin
        posCnt <= posCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stat.fasHit  = (window == FAS_WORD);
    stat.spareOk = window[PAT_W-1];
    stat.hitNow  = bitEn && stat.fasHit;
    stat.atCheck = bitEn && (posCnt == CNT_W'(SLOT_BITS));
    stat.atWrap  = bitEn && lastBit;
    stat.curFas  = fasPhase;
  end

  assign posLess = posCnt - 1'b1;
  assign bitNum  = posCnt;
  assign slotNum = posLess[SLOT_SH +: SLOT_W];

endmodule

// File: rtl/e1fa_control.sv
module e1fa_control
  import e1fa_pkg::*;
#(
  parameter int LOSS_LIMIT = 3,
  localparam int ERR_W = $clog2(LOSS_LIMIT + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      inFrame
);

  alignSt_t         state;
  logic [ERR_W-1:0] fasErr;
  logic [ERR_W-1:0] spareErr;

  always_comb strb.lock = (state == ST_HUNT) && stat.hitNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      inFrame  <= 1'b0;
      fasErr   <= '0;
      spareErr <= '0;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (stat.hitNow) state <= ST_WANT_ABSENT;
        end
        ST_WANT_ABSENT: begin
          if (stat.atCheck) state <= stat.fasHit ? ST_HOLD_OFF : ST_WANT_PRESENT;
        end
        ST_HOLD_OFF: begin
          if (stat.atWrap) state <= ST_HUNT;
        end
        ST_WANT_PRESENT: begin
          if (stat.atCheck) begin
            if (stat.fasHit) begin
              state    <= ST_LOCKED;
              inFrame  <= 1'b1;
              fasErr   <= '0;
              spareErr <= '0;
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_LOCKED: begin
          if (stat.atCheck) begin
            if (stat.curFas) begin
              if (stat.fasHit) begin
                fasErr <= '0;
              end else if (fasErr == ERR_W'(LOSS_LIMIT - 1)) begin
                state    <= ST_HUNT;
                inFrame  <= 1'b0;
                fasErr   <= '0;
                spareErr <= '0;
              end else begin
                fasErr <= fasErr + 1'b1;
              end
            end else begin
              if (stat.spareOk) begin
                spareErr <= '0;
              end else if (spareErr == ERR_W'(LOSS_LIMIT - 1)) begin
                state    <= ST_HUNT;
                inFrame  <= 1'b0;
                fasErr   <= '0;
                spareErr <= '0;
              end else begin
                spareErr <= spareErr + 1'b1;
              end
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/e1fa_top.sv
module e1fa_top
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter logic [SLOT_BITS-2:0] FAS_WORD = 7'b0011011,
  parameter int LOSS_LIMIT = 3,
  localparam int CNT_W  = $clog2(FRAME_BITS + 1),
  localparam int SLOT_W = $clog2(FRAME_BITS / SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              bitIn,
  output logic              inFrame,
  output logic [CNT_W-1:0]  bitNum,
  output logic [SLOT_W-1:0] slotNum,
  output logic              frameStart,
  output logic              fasFrame
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  e1fa_datapath #(
    .FRAME_BITS(FRAME_BITS),
    .SLOT_BITS (SLOT_BITS),
    .FAS_WORD  (FAS_WORD)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .bitEn  (bitEn),
    .bitIn  (bitIn),
    .strb   (strb),
    .stat   (stat),
    .bitNum (bitNum),
    .slotNum(slotNum)
  );

  e1fa_control #(
    .LOSS_LIMIT(LOSS_LIMIT)
  ) ctl_i (
    .clk    (clk),
    .rst    (rst),
    .stat   (stat),
    .strb   (strb),
    .inFrame(inFrame)
  );

  assign frameStart = inFrame && (bitNum == CNT_W'(1));
  assign fasFrame   = inFrame && stat.curFas;

endmodule

// File: rtl/e1fa_chk.sv
module e1fa_chk #(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             bitEn,
  input logic             inFrame,
  input logic [CNT_W-1:0] bitNum,
  input logic             frameStart,
  input logic             fasFrame
);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(bitNum) && $stable(inFrame)));

  // R8
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    inFrame |-> (bitNum >= CNT_W'(1) && bitNum <= CNT_W'(FRAME_BITS)));

  // R8
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inFrame && bitEn && bitNum != CNT_W'(FRAME_BITS)) |=>
      (bitNum == CNT_W'($past(bitNum) + 1'b1)));

  // R8
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inFrame && bitEn && bitNum == CNT_W'(FRAME_BITS)) |=> (bitNum == CNT_W'(1)));

  // R8
  start_flag_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (inFrame && bitNum == CNT_W'(1)));

  // R9
  fas_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fasFrame |-> inFrame);

  // R9
  fas_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (inFrame && bitEn && bitNum == CNT_W'(FRAME_BITS)) |=> (fasFrame != $past(fasFrame)));

  // R3
  gain_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inFrame) |-> (bitNum == CNT_W'(SLOT_BITS + 1) && fasFrame));

  // R6
  loss_pos_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(inFrame) && !$past(rst)) |-> (bitNum == CNT_W'(SLOT_BITS + 1)));

endmodule

bind e1fa_top e1fa_chk #(
  .FRAME_BITS(FRAME_BITS),
  .SLOT_BITS (SLOT_BITS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bitEn     (bitEn),
  .inFrame   (inFrame),
  .bitNum    (bitNum),
  .frameStart(frameStart),
  .fasFrame  (fasFrame)
);

// File: tb/e1fa_top_tb_top.sv
module e1fa_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitEn = 1'b0;
  logic       bitIn = 1'b0;
  logic       inFrame;
  logic [8:0] bitNum;
  logic [4:0] slotNum;
  logic       frameStart;
  logic       fasFrame;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  e1fa_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .bitIn     (bitIn),
    .inFrame   (inFrame),
    .bitNum    (bitNum),
    .slotNum   (slotNum),
    .frameStart(frameStart),
    .fasFrame  (fasFrame)
  );

  // {timeslot 0 byte (bit 1 = MSB), expected inFrame, expected fasFrame}
  // sampled right after bit 8 of timeslot 0 of each frame
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h1B, 1'b0, 1'b0},  // R3 candidate
    {8'h40, 1'b0, 1'b0},
    {8'h1B, 1'b1, 1'b1},  // R3 aligned
    {8'h40, 1'b1, 1'b0},
    {8'h1F, 1'b1, 1'b1},  // R6 bad 1
    {8'h40, 1'b1, 1'b0},
    {8'h9B, 1'b1, 1'b1},  // R2 bit 1 ignored, R6 count cleared
    {8'h40, 1'b1, 1'b0},
    {8'h1F, 1'b1, 1'b1},  // R6 bad 1
    {8'h00, 1'b1, 1'b0},  // R7 bad 1
    {8'h1F, 1'b1, 1'b1},  // R6 bad 2
    {8'h00, 1'b1, 1'b0},  // R7 bad 2
    {8'h9B, 1'b1, 1'b1},  // R6 cleared
    {8'h40, 1'b1, 1'b0},  // R7 cleared
    {8'h1F, 1'b1, 1'b1},
    {8'h40, 1'b1, 1'b0},
    {8'h1F, 1'b1, 1'b1},
    {8'h40, 1'b1, 1'b0},
    {8'h1F, 1'b0, 1'b0},  // R6 third bad word: loss
    {8'h40, 1'b0, 1'b0},
    {8'h9B, 1'b0, 1'b0},  // R2 candidate with bit 1 set
    {8'h00, 1'b0, 1'b0},  // R3 bit 2 not examined here
    {8'h1B, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b0},  // R7 bad 1
    {8'h1B, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b0},  // R7 bad 2
    {8'h1B, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0}   // R7 third bad bit 2: loss
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitIn = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic sendZeros(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  // payload of 31 slots, with an optional decoy word in one slot
  task automatic sendPayload(input int decoySlot);
    for (int s = 1; s < 32; s++) sendByte(s == decoySlot ? 8'h1B : 8'h00);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    bitEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    check("R1 inFrame", int'(inFrame), 0);
    check("R1 frameStart", int'(frameStart), 0);
    check("R1 fasFrame", int'(fasFrame), 0);
    check("R1 bitNum", int'(bitNum), 1);

    // table walk: R2 R3 R6 R7 R9
    sendZeros(37);
    for (int k = 0; k < NVEC; k++) begin
      sendByte(VEC[k][9:2]);
      check($sformatf("R3/R6/R7 inFrame frame %0d", k), int'(inFrame), int'(VEC[k][1]));
      check($sformatf("R9 fasFrame frame %0d", k), int'(fasFrame), int'(VEC[k][0]));
      if (VEC[k][1]) check($sformatf("R8 bitNum frame %0d", k), int'(bitNum), 9);
      sendPayload(0);
    end

    // R4: decoy repeated one frame later, then genuine words
    doReset();
    sendZeros(20);
    sendByte(8'h40); sendPayload(10);
    sendByte(8'h40); sendPayload(10);
    sendByte(8'h1B); sendPayload(0);
    check("R4 after hold-off frame", int'(inFrame), 0);
    sendByte(8'h40); sendPayload(0);
    sendByte(8'h1B);
    check("R4 no early lock", int'(inFrame), 0);
    sendPayload(0);
    sendByte(8'h40); sendPayload(0);
    sendByte(8'h1B);
    check("R4 lock two frames later", int'(inFrame), 1);
    sendPayload(0);

    // R5: decoy missing in its third frame, genuine word right after
    doReset();
    sendZeros(20);
    sendByte(8'h40); sendPayload(10);
    sendByte(8'h1B); sendPayload(0);
    sendByte(8'h40); sendPayload(0);
    check("R5 decoy rejected", int'(inFrame), 0);
    sendByte(8'h1B);
    check("R5 candidate only", int'(inFrame), 0);
    sendPayload(0);
    sendByte(8'h40);
    check("R5 candidate n+1", int'(inFrame), 0);
    sendPayload(0);
    sendByte(8'h1B);
    check("R5 aligned", int'(inFrame), 1);
    check("R8 slotNum after ts0", int'(slotNum), 1);

    // R10: idle cycles with toggling data
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bitEn = 1'b0;
      bitIn = i[0];
    end
    @(negedge clk);
    check("R10 bitNum held", int'(bitNum), 9);
    check("R10 inFrame held", int'(inFrame), 1);

    // R8 R9 position outputs across a wrap
    sendZeros(8);
    check("R8 bitNum mid", int'(bitNum), 17);
    check("R8 slotNum mid", int'(slotNum), 2);
    check("R8 frameStart mid", int'(frameStart), 0);
    sendZeros(240);
    check("R8 frameStart at wrap", int'(frameStart), 1);
    check("R8 bitNum at wrap", int'(bitNum), 1);
    check("R8 slotNum at wrap", int'(slotNum), 0);
    check("R9 fasFrame after wrap", int'(fasFrame), 0);
    sendByte(8'h40);
    sendZeros(247);
    check("R8 bitNum last", int'(bitNum), 256);
    check("R8 slotNum last", int'(slotNum), 31);
    sendBit(1'b0);
    check("R9 fasFrame alternates", int'(fasFrame), 1);

    // R1: reset while aligned
    doReset();
    check("R1 inFrame after reset", int'(inFrame), 0);
    check("R1 bitNum after reset", int'(bitNum), 1);
    check("R1 frameStart after reset", int'(frameStart), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule